// File: doc/BRIEF.md
# Speculation Token Register File

This block is a general-purpose register file in which every entry carries one extra poison bit, the token, stored beside the data word and never folded into it. Writebacks arrive on one write port. Each writeback is an ALU result, an ordinary load or a speculative load. Any writeback whose sources carry a token passes a set token on to its destination, so every value computed from a failed speculative load stays marked.

A speculative load that faults is either absorbed into a token or reported on the exception port. The choice depends on a software-written policy: one defer bit per fault class, and a mode bit that picks eager or minimal deferral. A check operation reads one register through read port A. When that register carries a token, the block signals a redirect to a recovery address on the following cycle. Faults on ordinary loads are always reported.

Top module: `spec_token_regfile`

## Requirements
- R1: After reset every register reads data 0 with token 0, the defer mask is all zeros and the mode is eager (0). With the reset policy, a faulting speculative load is reported as an exception.
- R2: Register 0 always reads data 0 with token 0, and writes to it have no effect.
- R3: A read on either port of the register being written in the same cycle returns the new data and token before the clock edge (write-first). Other reads return the stored contents.
- R4: `wb_kind` 0 is ALU, 1 is load, 2 is speculative load and 3 is no-op. A non-faulting write whose used sources are all clean stores `wb_data` with token 0.
- R5: The destination token of an ALU write, or of a non-faulting load, is the OR of the stored tokens of the used sources. Bit 0 of `wb_src_use` selects the register on port A and bit 1 the register on port B.
- R6: A faulting ordinary load never writes its destination. One cycle later it raises `exc_valid` with `exc_spec`=0, together with its class and destination, whatever the policy says.
- R7: In eager mode, a faulting speculative load whose class bit in the defer mask is 1 writes data 0 with token 1 and raises no exception.
- R8: In minimal mode (mode 1), a faulting speculative load is deferred into a token only if `wb_fault_visible` is 1 and its class bit is 1. Otherwise it raises `exc_valid` with `exc_spec`=1 and leaves its destination unchanged.
- R9: In either mode, a faulting speculative load whose class bit is 0 is reported with `exc_spec`=1 and does not write its destination.
- R10: A speculative load whose used sources carry a token writes data 0 with token 1 and raises no exception, even if it also faults.
- R11: When `chk_valid` is high, the register addressed on port A is tested. One cycle later `chk_taken` is 1 with `chk_redirect` equal to `chk_target` if its token (write-first) was set. Otherwise `chk_taken` is 0. This holds for the loaded register and for any register derived from it.
- R12: When `pol_we` is high, the defer mask and the mode take `pol_mask_in` and `pol_minimal_in` on that clock edge. Bit i of the mask is fault class i, and 1 means defer in hardware.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pol_we | input | 1 | Policy write strobe |
| pol_mask_in | input | 8 | Per-class defer bits |
| pol_minimal_in | input | 1 | Mode: 0 eager, 1 minimal |
| rd_a_addr | input | 5 | Read port A address, also the check source |
| rd_b_addr | input | 5 | Read port B address |
| rd_a_data | output | 32 | Port A data |
| rd_a_tok | output | 1 | Port A token |
| rd_b_data | output | 32 | Port B data |
| rd_b_tok | output | 1 | Port B token |
| wb_valid | input | 1 | Writeback request |
| wb_kind | input | 2 | 0 ALU, 1 load, 2 speculative load, 3 no-op |
| wb_dst | input | 5 | Destination register |
| wb_data | input | 32 | Result or loaded data |
| wb_src_use | input | 2 | Sources used: bit 0 port A, bit 1 port B |
| wb_fault | input | 1 | The load faulted |
| wb_fault_cls | input | 3 | Fault class |
| wb_fault_visible | input | 1 | The fault is known to be programmer-visible |
| chk_valid | input | 1 | Check request on port A register |
| chk_target | input | 32 | Recovery address |
| chk_taken | output | 1 | Redirect to recovery code |
| chk_redirect | output | 32 | Recovery address when taken |
| exc_valid | output | 1 | Fault reported to the OS handler |
| exc_spec | output | 1 | The reported fault came from a speculative load |
| exc_cls | output | 3 | Reported fault class |
| exc_dst | output | 5 | Destination of the faulting load |

## Verification
Random writebacks mix all four kinds with random faults, classes, visibility flags and source selections. The policy is rewritten at intervals, so the same fault patterns meet eager and minimal mode under different masks, which separates the deferral rule from the plain exception path. Checks on chains of dependent ALU writes tell a token that propagates through a chain from one that stays on the loaded register only. Directed cases cover register 0, same-cycle write/read bypass, a tainted speculative load that also faults, and a fault on an ordinary load under an all-ones mask.

// File: rtl/ntok_pkg.sv
package ntok_pkg;
    parameter int unsigned NREG   = 32;
    parameter int unsigned XLEN   = 32;
    parameter int unsigned NCLASS = 8;
    parameter int unsigned PCW    = 32;
    parameter int unsigned NRD    = 2;

    localparam int unsigned AW = $clog2(NREG);
    localparam int unsigned CW = $clog2(NCLASS);

    typedef enum logic [1:0] {
        WB_ALU   = 2'd0,
        WB_LOAD  = 2'd1,
        WB_SLOAD = 2'd2,
        WB_NOP   = 2'd3
    } wb_kind_e;

    typedef struct packed {
        logic [XLEN-1:0] data;
        logic            tok;
    } tagged_word_t;

    typedef struct packed {
        logic            en;
        logic [AW-1:0]   addr;
        tagged_word_t    word;
    } wr_req_t;

    typedef struct packed {
        logic            valid;
        logic            spec;
        logic [CW-1:0]   cls;
        logic [AW-1:0]   dst;
    } exc_info_t;

    // Hardware absorbs the fault when its class is enabled and, in minimal
    // mode, only when the fault is already known to be visible.
    function automatic logic may_defer(input logic [NCLASS-1:0] mask,
                                       input logic [CW-1:0]     cls,
                                       input logic              minimal,
                                       input logic              visible);
        return mask[cls] & (~minimal | visible);
    endfunction
endpackage

// File: rtl/tokreg_bank.sv
module tokreg_bank
    import ntok_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  wr_req_t      wr,
    input  logic [AW-1:0] rd_addr [NRD],
    output tagged_word_t rd_word [NRD],
    output tagged_word_t rd_held [NRD]
);
    tagged_word_t mem_q [NREG];
    logic         wr_live;

    assign wr_live = wr.en && (wr.addr != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(NREG); i++) mem_q[i] <= '0;
        end else if (wr_live) begin
            mem_q[wr.addr] <= wr.word;
        end
    end

    for (genvar p = 0; p < int'(NRD); p++) begin : g_port
        always_comb begin
            rd_held[p] = (rd_addr[p] == '0) ? '0 : mem_q[rd_addr[p]];
            rd_word[p] = (wr_live && wr.addr == rd_addr[p]) ? wr.word : rd_held[p];
        end

        // R2
        r0_clean_chk: assert property (@(posedge clk) disable iff (rst)
            (rd_addr[p] == '0) |-> (rd_word[p] == '0));
    end

    // R3
    stored_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_live |=> (mem_q[$past(wr.addr)] == $past(wr.word)));
endmodule

// File: rtl/defer_policy_unit.sv
module defer_policy_unit
    import ntok_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  wb_kind_e          kind,
    input  logic              fault,
    input  logic              visible,
    input  logic [CW-1:0]     cls,
    input  logic              src_tok,
    input  logic [XLEN-1:0]   data_in,
    input  logic [NCLASS-1:0] mask,
    input  logic              minimal,
    output logic              wr_en,
    output tagged_word_t      wr_word,
    output logic              exc_raise,
    output logic              exc_spec
);
    logic absorb;

    assign absorb = may_defer(mask, cls, minimal, visible);

    always_comb begin
        wr_en        = 1'b0;
        wr_word.data = data_in;
        wr_word.tok  = 1'b0;
        exc_raise    = 1'b0;
        exc_spec     = 1'b0;
        if (valid) begin
            unique case (kind)
                WB_ALU: begin
                    wr_en       = 1'b1;
                    wr_word.tok = src_tok;
                end
                WB_LOAD: begin
                    if (fault) begin
                        exc_raise = 1'b1;
                    end else begin
                        wr_en       = 1'b1;
                        wr_word.tok = src_tok;
                    end
                end
                WB_SLOAD: begin
                    if (src_tok || (fault && absorb)) begin
                        wr_en        = 1'b1;
                        wr_word.tok  = 1'b1;
                        wr_word.data = '0;
                    end else if (fault) begin
                        exc_raise = 1'b1;
                        exc_spec  = 1'b1;
                    end else begin
                        wr_en = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R6
    plain_fault_raises_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && kind == WB_LOAD && fault) |-> (exc_raise && !exc_spec && !wr_en));

    // R10
    tainted_sload_token_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && kind == WB_SLOAD && src_tok) |-> (wr_en && wr_word.tok && !exc_raise));

    // R9
    masked_off_reported_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && kind == WB_SLOAD && fault && !src_tok && !mask[cls]) |-> (exc_raise && exc_spec));
endmodule

// File: rtl/spec_check_unit.sv
module spec_check_unit
    import ntok_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           chk_valid,
    input  logic           src_tok,
    input  logic [PCW-1:0] target,
    output logic           taken,
    output logic [PCW-1:0] redirect
);
    always_ff @(posedge clk) begin
        if (rst) begin
            taken    <= 1'b0;
            redirect <= '0;
        end else begin
            taken    <= chk_valid && src_tok;
            redirect <= (chk_valid && src_tok) ? target : '0;
        end
    end

    // R11
    check_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && src_tok) |=> (taken && redirect == $past(target)));

    // R11
    check_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(chk_valid && src_tok) |=> !taken);
endmodule

// File: rtl/spec_token_regfile.sv
module spec_token_regfile
    import ntok_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pol_we,
    input  logic [NCLASS-1:0]     pol_mask_in,
    input  logic                  pol_minimal_in,
    input  logic [AW-1:0]         rd_a_addr,
    input  logic [AW-1:0]         rd_b_addr,
    output logic [XLEN-1:0]       rd_a_data,
    output logic                  rd_a_tok,
    output logic [XLEN-1:0]       rd_b_data,
    output logic                  rd_b_tok,
    input  logic                  wb_valid,
    input  logic [1:0]            wb_kind,
    input  logic [AW-1:0]         wb_dst,
    input  logic [XLEN-1:0]       wb_data,
    input  logic [NRD-1:0]        wb_src_use,
    input  logic                  wb_fault,
    input  logic [CW-1:0]         wb_fault_cls,
    input  logic                  wb_fault_visible,
    input  logic                  chk_valid,
    input  logic [PCW-1:0]        chk_target,
    output logic                  chk_taken,
    output logic [PCW-1:0]        chk_redirect,
    output logic                  exc_valid,
    output logic                  exc_spec,
    output logic [CW-1:0]         exc_cls,
    output logic [AW-1:0]         exc_dst
);
    logic [NCLASS-1:0] mask_q;
    logic              minimal_q;
    logic [AW-1:0]     rd_addr [NRD];
    tagged_word_t      rd_word [NRD];
    tagged_word_t      rd_held [NRD];
    logic [NRD-1:0]    used_tok;
    logic              src_tok;
    wr_req_t           wreq;
    logic              wr_en;
    tagged_word_t      wr_word;
    logic              raise, raise_spec;
    exc_info_t         exc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q    <= '0;
            minimal_q <= 1'b0;
        end else if (pol_we) begin
            mask_q    <= pol_mask_in;
            minimal_q <= pol_minimal_in;
        end
    end

    assign rd_addr[0] = rd_a_addr;
    assign rd_addr[1] = rd_b_addr;

    // Sources are taken from stored state so the write never feeds itself.
    for (genvar p = 0; p < int'(NRD); p++) begin : g_src
        assign used_tok[p] = wb_src_use[p] & rd_held[p].tok;
    end
    assign src_tok = |used_tok;

    defer_policy_unit u_policy (
        .clk       (clk),
        .rst       (rst),
        .valid     (wb_valid),
        .kind      (wb_kind_e'(wb_kind)),
        .fault     (wb_fault),
        .visible   (wb_fault_visible),
        .cls       (wb_fault_cls),
        .src_tok   (src_tok),
        .data_in   (wb_data),
        .mask      (mask_q),
        .minimal   (minimal_q),
        .wr_en     (wr_en),
        .wr_word   (wr_word),
        .exc_raise (raise),
        .exc_spec  (raise_spec)
    );

    assign wreq.en   = wr_en;
    assign wreq.addr = wb_dst;
    assign wreq.word = wr_word;

    tokreg_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr      (wreq),
        .rd_addr (rd_addr),
        .rd_word (rd_word),
        .rd_held (rd_held)
    );

    assign rd_a_data = rd_word[0].data;
    assign rd_a_tok  = rd_word[0].tok;
    assign rd_b_data = rd_word[1].data;
    assign rd_b_tok  = rd_word[1].tok;

    spec_check_unit u_check (
        .clk       (clk),
        .rst       (rst),
        .chk_valid (chk_valid),
        .src_tok   (rd_word[0].tok),
        .target    (chk_target),
        .taken     (chk_taken),
        .redirect  (chk_redirect)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            exc_q <= '0;
        end else begin
            exc_q.valid <= raise;
            exc_q.spec  <= raise_spec;
            exc_q.cls   <= wb_fault_cls;
            exc_q.dst   <= wb_dst;
        end
    end

    assign exc_valid = exc_q.valid;
    assign exc_spec  = exc_q.spec;
    assign exc_cls   = exc_q.cls;
    assign exc_dst   = exc_q.dst;

    // R12
    policy_load_chk: assert property (@(posedge clk) disable iff (rst)
        pol_we |=> (mask_q == $past(pol_mask_in) && minimal_q == $past(pol_minimal_in)));

    // R6
    exc_needs_fault_chk: assert property (@(posedge clk) disable iff (rst)
        !(wb_valid && wb_fault) |=> !exc_valid);

    // R7
    eager_absorb_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && wb_kind == 2'd2 && wb_fault && !minimal_q && mask_q[wb_fault_cls]) |=> !exc_valid);
endmodule

// File: tb/test_spec_token_regfile.sv
module test_spec_token_regfile;
    import ntok_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, pol_we, pol_minimal_in;
    logic [NCLASS-1:0] pol_mask_in;
    logic [AW-1:0] rd_a_addr, rd_b_addr, wb_dst, exc_dst;
    logic [XLEN-1:0] rd_a_data, rd_b_data, wb_data;
    logic rd_a_tok, rd_b_tok, wb_valid, wb_fault, wb_fault_visible;
    logic [1:0] wb_kind, wb_src_use;
    logic [CW-1:0] wb_fault_cls, exc_cls;
    logic chk_valid, chk_taken, exc_valid, exc_spec;
    logic [PCW-1:0] chk_target, chk_redirect;

    spec_token_regfile i_spec_token_regfile (.*);

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    logic [XLEN-1:0] m_data [NREG];
    logic            m_tok  [NREG];
    logic [NCLASS-1:0] m_mask;
    logic m_min;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        pol_we = 0; wb_valid = 0; chk_valid = 0; wb_fault = 0;
        wb_kind = 2'd3; wb_src_use = 0;
    endtask

    function automatic logic exp_absorb(input logic [CW-1:0] c, input logic vis);
        return m_mask[c] && (!m_min || vis);
    endfunction

    task automatic run_op(input logic [1:0] k, input logic [AW-1:0] d, a, b,
                          input logic [1:0] use_, input logic [XLEN-1:0] v,
                          input logic f, input logic [CW-1:0] c, input logic vis,
                          input string tag);
        logic srct, we, et, ex, es;
        logic [XLEN-1:0] ed;
        srct = (use_[0] && m_tok[a]) || (use_[1] && m_tok[b]);
        we = 0; et = 0; ed = v; ex = 0; es = 0;
        case (k)
            2'd0: begin we = 1; et = srct; end
            2'd1: if (f) ex = 1; else begin we = 1; et = srct; end
            2'd2: if (srct || (f && exp_absorb(c, vis))) begin we = 1; et = 1; ed = '0; end
                  else if (f) begin ex = 1; es = 1; end
                  else we = 1;
            default: ;
        endcase
        wb_valid = 1; wb_kind = k; wb_dst = d; rd_a_addr = a; rd_b_addr = b;
        wb_src_use = use_; wb_data = v; wb_fault = f; wb_fault_cls = c; wb_fault_visible = vis;
        @(posedge clk); #2;
        idle();
        check({tag, " exc_valid"}, 64'(exc_valid), 64'(ex));
        if (ex) begin
            check({tag, " exc_spec"}, 64'(exc_spec), 64'(es));
            check({tag, " exc_cls"}, 64'(exc_cls), 64'(c));
            check({tag, " exc_dst"}, 64'(exc_dst), 64'(d));
        end
        if (we && d != 0) begin m_data[d] = ed; m_tok[d] = et; end
        rd_a_addr = d; #1;
        check({tag, " dst data"}, 64'(rd_a_data), 64'(m_data[d]));
        check({tag, " dst tok"}, 64'(rd_a_tok), 64'(m_tok[d]));
    endtask

    task automatic set_policy(input logic [NCLASS-1:0] mk, input logic mn);
        pol_we = 1; pol_mask_in = mk; pol_minimal_in = mn;
        @(posedge clk); #2;
        pol_we = 0; m_mask = mk; m_min = mn;
    endtask

    task automatic do_chk(input logic [AW-1:0] s, input logic [PCW-1:0] t, input string tag);
        chk_valid = 1; rd_a_addr = s; chk_target = t;
        @(posedge clk); #2;
        chk_valid = 0;
        check({tag, " chk_taken"}, 64'(chk_taken), 64'(m_tok[s]));
        if (m_tok[s]) check({tag, " chk_redirect"}, 64'(chk_redirect), 64'(t));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        idle();
        rd_a_addr = 0; rd_b_addr = 0; wb_dst = 0; wb_data = 0; wb_fault_cls = 0;
        wb_fault_visible = 0; chk_target = 0; pol_mask_in = 0; pol_minimal_in = 0;
        for (int i = 0; i < int'(NREG); i++) begin m_data[i] = '0; m_tok[i] = 0; end
        m_mask = 0; m_min = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        #2 rst = 0;

        // R1: reset contents and policy
        for (int r = 0; r < int'(NREG); r += 7) begin
            rd_b_addr = AW'(r); #1;
            check("R1 reset data", 64'(rd_b_data), 64'd0);
            check("R1 reset tok", 64'(rd_b_tok), 64'd0);
        end
        check("R1 no exc after reset", 64'(exc_valid), 64'd0);
        run_op(2'd2, 5'd6, 5'd0, 5'd0, 2'b00, 32'h1111, 1, 3'd2, 1, "R1 R9 reset policy reports");

        // R4: clean write
        run_op(2'd0, 5'd7, 5'd1, 5'd2, 2'b11, 32'hCAFE0001, 0, 0, 0, "R4 clean alu");

        // R2: register 0
        run_op(2'd0, 5'd0, 5'd0, 5'd0, 2'b00, 32'hFFFF_FFFF, 0, 0, 0, "R2 r0 write ignored");

        // R3: write-first bypass on both ports
        wb_valid = 1; wb_kind = 2'd0; wb_dst = 5'd9; wb_data = 32'h0BAD_F00D; wb_src_use = 0;
        rd_a_addr = 5'd9; rd_b_addr = 5'd9; #1;
        check("R3 bypass A data", 64'(rd_a_data), 64'h0BAD_F00D);
        check("R3 bypass B data", 64'(rd_b_data), 64'h0BAD_F00D);
        @(posedge clk); #2; idle();
        m_data[9] = 32'h0BAD_F00D; m_tok[9] = 0;

        // R7: eager deferral, then R5 chain, R11 check of derived register
        set_policy(8'b0000_0100, 0);
        run_op(2'd2, 5'd3, 5'd0, 5'd0, 2'b00, 32'h1234, 1, 3'd2, 0, "R7 eager defer");
        run_op(2'd0, 5'd4, 5'd3, 5'd7, 2'b11, 32'h55, 0, 0, 0, "R5 chain step 1");
        run_op(2'd0, 5'd5, 5'd9, 5'd4, 2'b10, 32'h66, 0, 0, 0, "R5 chain step 2");
        run_op(2'd0, 5'd8, 5'd4, 5'd9, 2'b10, 32'h77, 0, 0, 0, "R5 unused source ignored");
        do_chk(5'd3, 32'h4000_0100, "R11 loaded reg");
        do_chk(5'd5, 32'h4000_0200, "R11 derived reg");
        do_chk(5'd9, 32'h4000_0300, "R11 clean reg");

        // R10: tainted speculative load that also faults
        set_policy(8'b0000_0000, 1);
        run_op(2'd2, 5'd10, 5'd5, 5'd0, 2'b01, 32'h99, 1, 3'd1, 0, "R10 tainted sload");
        // R6: ordinary load fault with all-ones mask
        set_policy(8'hFF, 0);
        run_op(2'd1, 5'd9, 5'd0, 5'd0, 2'b00, 32'h1, 1, 3'd5, 1, "R6 plain fault");
        // R8: minimal mode visibility
        set_policy(8'hFF, 1);
        run_op(2'd2, 5'd11, 5'd0, 5'd0, 2'b00, 32'h2, 1, 3'd0, 0, "R8 minimal not visible");
        run_op(2'd2, 5'd11, 5'd0, 5'd0, 2'b00, 32'h2, 1, 3'd0, 1, "R8 minimal visible");
        // R4: clean rewrite clears token
        run_op(2'd1, 5'd11, 5'd9, 5'd0, 2'b01, 32'h3, 0, 0, 0, "R4 clean load clears tok");

        // Random mix
        for (int n = 0; n < 1500; n++) begin
            if (n % 40 == 0) set_policy(NCLASS'($urandom), 1'($urandom));
            if ($urandom % 6 == 0)
                do_chk(AW'($urandom), $urandom, "R11 random");
            else
                run_op(2'($urandom), AW'($urandom), AW'($urandom), AW'($urandom),
                       2'($urandom), $urandom, ($urandom % 3 == 0), CW'($urandom),
                       1'($urandom), "R5 R7 R8 R9 random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule